// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C master, together with the phase strobes that tell the transfer engine when to change SDA, when SDA must be valid, when to sample SDA, and when to toggle SDA for a start or stop condition. All timing is measured in cycles of the internal operating clock, which runs at 50 MHz. Four count inputs set the block's timing: the bit period, the low time, the setup time for start and stop conditions, and the data setup time. Typical values are half the period for the low time and the condition setup, and one sixteenth of the period for data setup. The highest supported bus rate is 400 kHz, which is a period of 125 cycles.

The block is a state machine with four states. SG_IDLE is the resting state. SG_LOW drives SCL low. SG_HIGH releases SCL and counts only the cycles in which SCL is read back high, so a target that stretches the clock pauses the count. SG_HOLD keeps SCL high after a condition strobe. The transitions are as follows. SG_IDLE goes to SG_LOW when the run control is set. SG_LOW goes to SG_HIGH after its last low cycle. SG_HIGH goes back to SG_LOW, or to SG_IDLE if run has been cleared, after its last high cycle. SG_HIGH goes to SG_HOLD after a condition strobe. SG_HOLD goes to SG_LOW or to SG_IDLE once its hold count expires.

On entry to SG_LOW the clamped timing values are copied into shadow registers. The count inputs can therefore change at any time without disturbing the bit in flight. With run clear, the block waits in SG_IDLE, which is the safe moment to reprogram it. A separate release control holds SCL low whenever it is clear.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: After reset the block is in SG_IDLE: busy is 0, no strobe is asserted, and scl_oe equals the inverse of ctl_release.
- R2: Each bit begins with a low phase in which scl_oe is 1 for exactly L cycles, where L is the effective low count.
- R3: With no stretching, the high phase lasts H = P - L cycles with scl_oe at 0. P is the effective period, equal to cfg_period, or 2 if cfg_period is below 2.
- R4: L equals cfg_low, except when cfg_low is 0 or not smaller than P; in that case L = P/2, rounded down.
- R5: The high-phase counter advances only in cycles where scl_in is 1. While a target holds SCL low, the high phase is extended by those cycles and no strobe fires.
- R6: sda_change pulses in low-phase cycle 0. sda_valid pulses in low-phase cycle L - D, where D is cfg_data_setup, taken as 1 when it is 0 and capped at L.
- R7: sample_stb pulses once per normal bit, at high-phase cycle H/2 rounded down, counting only cycles with SCL high from 0.
- R8: If cond_req is 1 in the last low cycle, that bit's high phase has no sample_stb. Instead, cond_stb pulses at high cycle S-1, SCL then stays high for S more cycles, and a new bit or idle follows. S is cfg_cond_setup, taken as 1 when it is 0.
- R9: The timing inputs are captured at the start of each low phase, so a change made mid-bit affects only the next bit. When ctl_run is cleared, the current bit completes and busy falls exactly when the next bit would have started.
- R10: While ctl_release is 0, scl_oe is 1 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | CNT_W | Bit period in operating-clock cycles |
| cfg_low | input | CNT_W | SCL low time in cycles |
| cfg_cond_setup | input | CNT_W | Setup time for start and stop conditions in cycles |
| cfg_data_setup | input | CNT_W | Number of cycles SDA must be valid before SCL rises |
| ctl_run | input | 1 | Run control; when 0 the block idles after the current bit |
| ctl_release | input | 1 | SCL release control; when 0, SCL is held low |
| cond_req | input | 1 | Request a start/stop condition slot in place of the next data sample |
| scl_in | input | 1 | SCL as read back from the bus (already synchronized) |
| scl_oe | output | 1 | 1 drives SCL low, 0 releases it |
| sda_change | output | 1 | Strobe: the engine may change SDA |
| sda_valid | output | 1 | Strobe: the data setup point has been reached |
| sample_stb | output | 1 | Strobe: sample SDA (middle of the high phase) |
| cond_stb | output | 1 | Strobe: toggle SDA to form the start or stop condition |
| busy | output | 1 | 1 whenever the block is not idle |

## Verification
The bench targets the clamp edges: a zero or oversized low count, a data setup of zero or larger than the low phase, and a period below two. A design that got these wrong would produce bits of the wrong length or would never emit sda_valid. A stretched high phase is checked for length and sample position, because a counter that ignores scl_in would sample SDA while SCL is still low. The condition path is checked for the strobe index and the hold length, since an off-by-one there shifts the start/stop edge against SCL. A change to the low count in the middle of a bit, and a run drop, are checked so that a design that reads the timing inputs live, or that stops mid-bit, produces a truncated clock pulse and is reported.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

    typedef enum logic [1:0] {
        SG_IDLE = 2'd0,
        SG_LOW  = 2'd1,
        SG_HIGH = 2'd2,
        SG_HOLD = 2'd3
    } sg_state_e;

endpackage

// File: rtl/sclgen_timing_clamp.sv
module sclgen_timing_clamp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] raw_period,
    input  logic [CNT_W-1:0] raw_low,
    input  logic [CNT_W-1:0] raw_dsu,
    input  logic [CNT_W-1:0] raw_cs,
    output logic [CNT_W-1:0] eff_low,
    output logic [CNT_W-1:0] eff_high,
    output logic [CNT_W-1:0] vld_idx,
    output logic [CNT_W-1:0] smp_idx,
    output logic [CNT_W-1:0] eff_cs
);
    localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(2);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    logic [CNT_W-1:0] per_e;
    logic [CNT_W-1:0] low_e;
    logic [CNT_W-1:0] dsu_e;

    always_comb begin
        per_e = (raw_period < MIN_PERIOD) ? MIN_PERIOD : raw_period;

        // zero or oversized low count falls back to half the period
        if (raw_low == '0 || raw_low >= per_e) begin
            low_e = per_e >> 1;
        end else begin
            low_e = raw_low;
        end

        if (raw_dsu == '0) begin
            dsu_e = ONE;
        end else if (raw_dsu > low_e) begin
            dsu_e = low_e;
        end else begin
            dsu_e = raw_dsu;
        end

        eff_low  = low_e;
        eff_high = per_e - low_e;
        vld_idx  = low_e - dsu_e;
        smp_idx  = (per_e - low_e) >> 1;
        eff_cs   = (raw_cs == '0) ? ONE : raw_cs;
    end

endmodule

// File: rtl/sclgen_phase_cnt.sv
module sclgen_phase_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/i2c_scl_timing_gen.sv
module i2c_scl_timing_gen
    import i2c_sclgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_cond_setup,
    input  logic [CNT_W-1:0] cfg_data_setup,
    input  logic             ctl_run,
    input  logic             ctl_release,
    input  logic             cond_req,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             sda_change,
    output logic             sda_valid,
    output logic             sample_stb,
    output logic             cond_stb,
    output logic             busy
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    sg_state_e state_q, state_d;

    logic [CNT_W-1:0] c_low, c_high, c_vld, c_smp, c_cs;
    logic [CNT_W-1:0] sh_low, sh_high, sh_vld, sh_smp, sh_cs;
    logic [CNT_W-1:0] cnt;
    logic             cond_q;
    logic             cnt_clr, cnt_en, enter_low;
    logic             last_low, hi_last_norm, hi_last_cond, hold_last;

    sclgen_timing_clamp #(.CNT_W(CNT_W)) u_clamp (
        .raw_period (cfg_period),
        .raw_low    (cfg_low),
        .raw_dsu    (cfg_data_setup),
        .raw_cs     (cfg_cond_setup),
        .eff_low    (c_low),
        .eff_high   (c_high),
        .vld_idx    (c_vld),
        .smp_idx    (c_smp),
        .eff_cs     (c_cs)
    );

    sclgen_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .cnt   (cnt)
    );

    // phase end detection
    always_comb begin
        last_low     = (state_q == SG_LOW) && (cnt == sh_low - ONE);
        hi_last_norm = (state_q == SG_HIGH) && !cond_q && scl_in && (cnt == sh_high - ONE);
        hi_last_cond = (state_q == SG_HIGH) && cond_q && scl_in && (cnt == sh_cs - ONE);
        hold_last    = (state_q == SG_HOLD) && (cnt == sh_cs - ONE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SG_IDLE: if (ctl_run) state_d = SG_LOW;
            SG_LOW:  if (last_low) state_d = SG_HIGH;
            SG_HIGH: begin
                if (hi_last_norm) begin
                    state_d = ctl_run ? SG_LOW : SG_IDLE;
                end else if (hi_last_cond) begin
                    state_d = SG_HOLD;
                end
            end
            SG_HOLD: if (hold_last) state_d = ctl_run ? SG_LOW : SG_IDLE;
            default: state_d = SG_IDLE;
        endcase
    end

    assign enter_low = (state_d == SG_LOW) && (state_q != SG_LOW);
    assign cnt_clr   = (state_d != state_q);
    assign cnt_en    = (state_q == SG_HIGH) ? scl_in : 1'b1;

    // state register, condition flag and per-bit shadow timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SG_IDLE;
            cond_q  <= 1'b0;
            sh_low  <= ONE;
            sh_high <= ONE;
            sh_vld  <= '0;
            sh_smp  <= '0;
            sh_cs   <= ONE;
        end else begin
            state_q <= state_d;
            if (last_low) begin
                cond_q <= cond_req;
            end
            if (enter_low) begin
                sh_low  <= c_low;
                sh_high <= c_high;
                sh_vld  <= c_vld;
                sh_smp  <= c_smp;
                sh_cs   <= c_cs;
            end
        end
    end

    // outputs
    always_comb begin
        scl_oe     = (state_q == SG_LOW) || !ctl_release;
        sda_change = (state_q == SG_LOW) && (cnt == '0);
        sda_valid  = (state_q == SG_LOW) && (cnt == sh_vld);
        sample_stb = (state_q == SG_HIGH) && !cond_q && scl_in && (cnt == sh_smp);
        cond_stb   = (state_q == SG_HIGH) && cond_q && scl_in && (cnt == sh_cs - ONE);
        busy       = (state_q != SG_IDLE);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_IDLE) |-> !(sda_change || sda_valid || sample_stb || cond_stb)); // R1
    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_LOW) |-> (cnt < sh_low)); // R2
    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_HIGH) |-> (cnt < (cond_q ? sh_cs : sh_high))); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_HIGH && !scl_in) |=> (cnt == $past(cnt))); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_stb, cond_stb, sda_change})); // R7
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SG_LOW && cnt != '0) |-> ($stable(sh_low) && $stable(sh_high))); // R9
    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_release |-> scl_oe); // R10

endmodule

// File: tb/i2c_scl_timing_gen_tb_top.sv
module i2c_scl_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_period = 16'd20, cfg_low = 16'd10, cfg_cond_setup = 16'd4, cfg_data_setup = 16'd3;
    logic        ctl_run = 1'b0, ctl_release = 1'b1, cond_req = 1'b0, stretch = 1'b0;
    logic        scl_in, scl_oe, sda_change, sda_valid, sample_stb, cond_stb, busy;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    assign scl_in = !scl_oe && !stretch;

    always #10 clk = ~clk;

    i2c_scl_timing_gen #(.CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_cond_setup(cfg_cond_setup), .cfg_data_setup(cfg_data_setup),
        .ctl_run(ctl_run), .ctl_release(ctl_release), .cond_req(cond_req),
        .scl_in(scl_in), .scl_oe(scl_oe), .sda_change(sda_change), .sda_valid(sda_valid),
        .sample_stb(sample_stb), .cond_stb(cond_stb), .busy(busy)
    );

    typedef struct packed {
        int per; int low; int dsu; int el; int eh; int ev; int es;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{125, 62, 7, 62, 63, 55, 31},
        '{125,  0, 7, 62, 63, 55, 31},
        '{ 20, 30, 3, 10, 10,  7,  5},
        '{ 20, 20, 0, 10, 10,  9,  5},
        '{ 20,  5, 9,  5, 15,  0,  7},
        '{  1,  0, 0,  1,  1,  0,  0},
        '{  3,  2, 1,  2,  1,  1,  0},
        '{ 16,  4, 2,  4, 12,  2,  6}
    };

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure_bit(output int lo, output int hi, output int vi, output int si);
        lo = 0; hi = 0; vi = -1; si = -1;
        while (!sda_change) @(negedge clk);
        while (scl_oe) begin
            if (sda_valid && vi < 0) vi = lo;
            lo++;
            @(negedge clk);
        end
        while (!scl_oe) begin
            if (sample_stb) si = hi;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(int p, int l, int d, int c);
        cfg_period = 16'(p); cfg_low = 16'(l); cfg_data_setup = 16'(d); cfg_cond_setup = 16'(c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lo, hi, vi, si, n, held, cidx;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 scl_oe released", scl_oe, 0);
        check("R1 strobes", int'({sda_change, sda_valid, sample_stb, cond_stb}), 0);
        ctl_release = 1'b0; #1;
        check("R10 idle force low", scl_oe, 1);
        ctl_release = 1'b1;
        @(negedge clk);

        // vector table: R2 R3 R4 R6 R7 R11-style period clamp (inside R3)
        for (int i = 0; i < 8; i++) begin
            set_cfg(VECS[i].per, VECS[i].low, VECS[i].dsu, 4);
            @(negedge clk);
            ctl_run = 1'b1;
            measure_bit(lo, hi, vi, si);
            ctl_run = 1'b0;
            check($sformatf("R2 R4 low len vec%0d", i), lo, VECS[i].el);
            check($sformatf("R3 high len vec%0d", i), hi, VECS[i].eh);
            check($sformatf("R6 valid idx vec%0d", i), vi, VECS[i].ev);
            check($sformatf("R7 sample idx vec%0d", i), si, VECS[i].es);
            wait_idle();
        end

        // R5 clock stretching
        set_cfg(20, 10, 3, 4);
        stretch = 1'b1;
        @(negedge clk);
        ctl_run = 1'b1;
        while (!sda_change) @(negedge clk);
        while (scl_oe) @(negedge clk);
        seen = 1'b0;
        for (int k = 0; k < 7; k++) begin
            if (sample_stb || cond_stb) seen = 1'b1;
            @(negedge clk);
        end
        stretch = 1'b0; #1;
        hi = 0; si = -1;
        while (!scl_oe) begin
            if (sample_stb) si = hi;
            hi++;
            @(negedge clk);
        end
        ctl_run = 1'b0;
        check("R5 no strobe while stretched", seen, 0);
        check("R5 high cycles after stretch", hi, 10);
        check("R5 sample idx after stretch", si, 5);
        wait_idle();

        // R8 condition slot, S=4
        set_cfg(20, 10, 3, 4);
        cond_req = 1'b1;
        @(negedge clk);
        ctl_run = 1'b1;
        while (!sda_change) @(negedge clk);
        lo = 0;
        while (scl_oe) begin lo++; @(negedge clk); end
        cond_req = 1'b0;
        hi = 0; cidx = -1; seen = 1'b0;
        while (!scl_oe) begin
            if (cond_stb) cidx = hi;
            if (sample_stb) seen = 1'b1;
            hi++;
            @(negedge clk);
        end
        check("R8 cond low len", lo, 10);
        check("R8 cond high plus hold", hi, 8);
        check("R8 cond strobe idx", cidx, 3);
        check("R8 no sample in cond bit", seen, 0);
        measure_bit(lo, hi, vi, si);
        ctl_run = 1'b0;
        check("R8 next bit high len", hi, 10);
        check("R8 next bit sample idx", si, 5);
        wait_idle();

        // R8 condition setup of zero taken as 1
        set_cfg(20, 10, 3, 0);
        cond_req = 1'b1;
        @(negedge clk);
        ctl_run = 1'b1;
        while (!sda_change) @(negedge clk);
        while (scl_oe) @(negedge clk);
        ctl_run = 1'b0;
        cond_req = 1'b0;
        hi = 0; cidx = -1;
        while (busy) begin
            if (cond_stb) cidx = hi;
            hi++;
            @(negedge clk);
        end
        check("R8 zero setup span", hi, 2);
        check("R8 zero setup strobe idx", cidx, 0);
        wait_idle();

        // R9 mid-bit config change only affects next bit
        set_cfg(20, 10, 3, 4);
        @(negedge clk);
        ctl_run = 1'b1;
        while (!sda_change) @(negedge clk);
        cfg_low = 16'd4;
        lo = 0;
        while (scl_oe) begin lo++; @(negedge clk); end
        check("R9 current bit keeps low", lo, 10);
        measure_bit(lo, hi, vi, si);
        check("R9 next bit uses new low", lo, 4);
        // R9 run drop: busy falls at the next bit boundary (we sit at its cycle 0)
        ctl_run = 1'b0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R9 bit completes before idle", n, 20);
        seen = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (sda_change || busy) seen = 1'b1;
            @(negedge clk);
        end
        check("R9 stays idle", seen, 0);

        // R10 force low while running
        set_cfg(20, 10, 3, 4);
        ctl_run = 1'b1;
        while (!sda_change) @(negedge clk);
        ctl_release = 1'b0;
        held = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (scl_oe) held++;
        end
        check("R10 scl held low while running", held, 40);
        ctl_release = 1'b1;
        ctl_run = 1'b0;
        wait_idle();
        check("R10 returns idle after release", busy, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule